// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Flag Register

This block performs the single-byte arithmetic and logic work of a small accumulator machine. One operand is the accumulator. The other is a second byte supplied by the surrounding datapath, and the current carry flag arrives on its own input. A four-bit operation code picks the function. The result, its write enable, the four proposed condition flags and a per-flag update mask all settle combinationally in the same cycle the inputs are presented.

Each operation has its own flag policy. Some flags follow the result, some are forced to a constant, and some are left alone. The per-flag mask expresses this, so the caller never has to know which is which. A small synchronous register holds the four condition flags. On each clock edge it copies in only the flags whose mask bit is set.

The flag register presents the flags packed in the upper nibble of a byte: zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. The lower nibble always reads zero. The increment and decrement operations step the second operand, so they can serve any register held by the datapath.

Top module: `acc_alu_core`

## Requirements
- R1: Add (op_sel 0) and add-with-carry (op_sel 1) write acc_in + opnd_in (+ carry_in for code 1) modulo 256. Z is set when the byte is zero, N is cleared, H marks a carry out of bit 3 and C a carry out of bit 7. The carry input counts in both carries, and all four flags are updated.
- R2: Subtract (op_sel 2) and subtract-with-carry (op_sel 3) write acc_in - opnd_in (- carry_in for code 3) modulo 256. Z follows the byte, N is set, H is set when the low nibble needs a borrow, and C is set when the subtrahend plus carry exceeds acc_in. All four flags are updated.
- R3: Compare (op_sel 4) produces the same four flags as subtract but holds result_we low.
- R4: AND (op_sel 5) writes the bitwise AND. Z follows the result, H is forced to 1, N and C are cleared, and all flags are updated.
- R5: OR (op_sel 6) and XOR (op_sel 7) write their bitwise result. Z follows the result, N, H and C are cleared, and all flags are updated.
- R6: Increment (op_sel 8) and decrement (op_sel 9) write opnd_in plus or minus one modulo 256. Z follows the result. N is 0 for increment and 1 for decrement. H marks a carry out of bit 3 or a borrow into the low nibble. The carry mask bit stays clear.
- R7: Complement (op_sel 10) writes the inverse of acc_in, sets N and H, and masks only those two flags.
- R8: Set-carry (op_sel 11) proposes C=1, and complement-carry (op_sel 12) proposes C = NOT carry_in. Both clear N and H, leave Z unmasked and hold result_we low.
- R9: flag_next and flag_mask order their bits as Z in bit 3, N in bit 2, H in bit 1 and C in bit 0. flags_q packs Z, N, H and C in bits 7, 6, 5 and 4, keeps bits 3..0 at zero, and is all zero after reset.
- R10: On each rising clock edge, flags_q loads exactly the flags whose mask bit is set and holds the others. While op_valid is low, the mask is zero and result_we is low.
- R11: The unassigned codes 13 to 15 drive result_we low and a zero mask, even with op_valid high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Qualifies the operation in this cycle |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Computed byte |
| result_we | output | 1 | Result is to be written back |
| flag_next | output | 4 | Proposed Z, N, H, C |
| flag_mask | output | 4 | Flags that this operation updates |
| flags_q | output | 8 | Registered flag byte |

## Verification
The embedded properties check, on every cycle, the per-flag policies that the inputs alone determine:
- compare never writes back;
- AND forces its half-carry;
- step operations never touch carry;
- set-carry proposes a carry without a write;
- an idle cycle is quiet;
- the zero flag agrees with any written result;
- every unmasked bit of the flag register holds across the edge.

The carry and half-carry values at nibble and byte boundaries, the role of the carry input in the carry-consuming operations, and the unassigned codes are shown only by the bench. It compares a wide sweep of operand pairs against an arithmetic model built from the requirements.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9,
        OP_CPL = 4'd10,
        OP_SCF = 4'd11,
        OP_CCF = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        LK_AND = 2'd0,
        LK_OR  = 2'd1,
        LK_XOR = 2'd2,
        LK_INV = 2'd3
    } logic_kind_e;

    // bit order Z,N,H,C from msb to lsb
    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag_t;

    localparam int FLAG_CNT = 4;

    localparam logic [FLAG_CNT-1:0] MSK_ALL   = 4'b1111;
    localparam logic [FLAG_CNT-1:0] MSK_STEP  = 4'b1110;
    localparam logic [FLAG_CNT-1:0] MSK_NH    = 4'b0110;
    localparam logic [FLAG_CNT-1:0] MSK_CARRY = 4'b0111;

endpackage

// File: rtl/acc_alu_addsub.sv
// Shared adder/subtractor. Subtraction uses x + ~y + ~bin; carries are
// inverted back so that the outputs always mean "carry" for add and
// "borrow" for subtract.
module acc_alu_addsub #(
    parameter int DATA_W = 8,
    parameter int HALF_W = 4
) (
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic              cb_in,
    input  logic              sub_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              full_out,
    output logic              half_out
);

    logic [DATA_W-1:0] y_eff;
    logic              c_eff;
    logic [DATA_W:0]   wide_tot;
    logic [HALF_W:0]   nib_tot;

    always_comb begin
        y_eff    = sub_in ? ~y_in : y_in;
        c_eff    = sub_in ? ~cb_in : cb_in;
        wide_tot = {1'b0, x_in} + {1'b0, y_eff} + {{DATA_W{1'b0}}, c_eff};
        nib_tot  = {1'b0, x_in[HALF_W-1:0]} + {1'b0, y_eff[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, c_eff};
        sum_out  = wide_tot[DATA_W-1:0];
        full_out = wide_tot[DATA_W] ^ sub_in;
        half_out = nib_tot[HALF_W] ^ sub_in;
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic_kind_e       kind_in,
    output logic [DATA_W-1:0] res_out
);

    always_comb begin
        case (kind_in)
            LK_AND:  res_out = a_in & b_in;
            LK_OR:   res_out = a_in | b_in;
            LK_XOR:  res_out = a_in ^ b_in;
            default: res_out = ~a_in;
        endcase
    end

endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
    import acc_alu_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int FLAG_LSB = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FLAG_CNT-1:0] upd_mask,
    input  logic [FLAG_CNT-1:0] upd_val,
    output logic [DATA_W-1:0]   flags_q
);

    logic [FLAG_CNT-1:0] fl_d;
    logic [FLAG_CNT-1:0] fl_q;

    for (genvar gi = 0; gi < FLAG_CNT; gi++) begin : g_bit
        always_comb begin
            fl_d[gi] = upd_mask[gi] ? upd_val[gi] : fl_q[gi];
        end

        // R10: an unmasked flag keeps its value across the edge
        a_r10_hold_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
            !upd_mask[gi] |=> flags_q[FLAG_LSB+gi] == $past(flags_q[FLAG_LSB+gi]));

        // R10: a masked flag takes the proposed value
        a_r10_load_masked: assert property (@(posedge clk) disable iff (!rst_n)
            upd_mask[gi] |=> flags_q[FLAG_LSB+gi] == $past(upd_val[gi]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    always_comb begin
        flags_q = '0;
        flags_q[FLAG_LSB +: FLAG_CNT] = fl_q;
    end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_W   = 4,
    parameter int OP_W     = 4,
    parameter int FLAG_LSB = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [OP_W-1:0]     op_sel,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic [DATA_W-1:0]   opnd_in,
    input  logic                carry_in,
    output logic [DATA_W-1:0]   result,
    output logic                result_we,
    output logic [FLAG_CNT-1:0] flag_next,
    output logic [FLAG_CNT-1:0] flag_mask,
    output logic [DATA_W-1:0]   flags_q
);

    typedef struct packed {
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic              cb;
        logic              sub;
        logic_kind_e       kind;
    } sel_t;

    typedef struct packed {
        logic [DATA_W-1:0]   res;
        logic                we;
        flag_t               fl;
        logic [FLAG_CNT-1:0] msk;
    } out_t;

    alu_op_e           op;
    sel_t              sel_d;
    out_t              out_d;
    logic [DATA_W-1:0] sum_w;
    logic              full_w;
    logic              half_w;
    logic [DATA_W-1:0] lres_w;

    assign op = alu_op_e'(op_sel);

    // operand steering for the shared adder and the logic unit
    always_comb begin
        sel_d      = '0;
        sel_d.x    = acc_in;
        sel_d.y    = opnd_in;
        sel_d.kind = LK_AND;
        case (op)
            OP_ADC:         sel_d.cb  = carry_in;
            OP_SUB, OP_CMP: sel_d.sub = 1'b1;
            OP_SBC: begin
                sel_d.sub = 1'b1;
                sel_d.cb  = carry_in;
            end
            OP_INC, OP_DEC: begin
                sel_d.x   = opnd_in;
                sel_d.y   = '0;
                sel_d.cb  = 1'b1;
                sel_d.sub = (op == OP_DEC);
            end
            OP_OR:   sel_d.kind = LK_OR;
            OP_XOR:  sel_d.kind = LK_XOR;
            OP_CPL:  sel_d.kind = LK_INV;
            default: ;
        endcase
    end

    acc_alu_addsub #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_addsub (
        .x_in    (sel_d.x),
        .y_in    (sel_d.y),
        .cb_in   (sel_d.cb),
        .sub_in  (sel_d.sub),
        .sum_out (sum_w),
        .full_out(full_w),
        .half_out(half_w)
    );

    acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_in   (acc_in),
        .b_in   (opnd_in),
        .kind_in(sel_d.kind),
        .res_out(lres_w)
    );

    // per-operation result and flag policy
    always_comb begin
        out_d     = '0;
        out_d.res = sum_w;
        case (op)
            OP_ADD, OP_ADC: begin
                out_d.we  = 1'b1;
                out_d.fl  = '{z: ~|sum_w, n: 1'b0, h: half_w, c: full_w};
                out_d.msk = MSK_ALL;
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                out_d.we  = (op != OP_CMP);
                out_d.fl  = '{z: ~|sum_w, n: 1'b1, h: half_w, c: full_w};
                out_d.msk = MSK_ALL;
            end
            OP_AND: begin
                out_d.res = lres_w;
                out_d.we  = 1'b1;
                out_d.fl  = '{z: ~|lres_w, n: 1'b0, h: 1'b1, c: 1'b0};
                out_d.msk = MSK_ALL;
            end
            OP_OR, OP_XOR: begin
                out_d.res = lres_w;
                out_d.we  = 1'b1;
                out_d.fl  = '{z: ~|lres_w, n: 1'b0, h: 1'b0, c: 1'b0};
                out_d.msk = MSK_ALL;
            end
            OP_INC, OP_DEC: begin
                out_d.we  = 1'b1;
                out_d.fl  = '{z: ~|sum_w, n: (op == OP_DEC), h: half_w, c: 1'b0};
                out_d.msk = MSK_STEP;
            end
            OP_CPL: begin
                out_d.res = lres_w;
                out_d.we  = 1'b1;
                out_d.fl  = '{z: 1'b0, n: 1'b1, h: 1'b1, c: 1'b0};
                out_d.msk = MSK_NH;
            end
            OP_SCF: begin
                out_d.fl  = '{z: 1'b0, n: 1'b0, h: 1'b0, c: 1'b1};
                out_d.msk = MSK_CARRY;
            end
            OP_CCF: begin
                out_d.fl  = '{z: 1'b0, n: 1'b0, h: 1'b0, c: ~carry_in};
                out_d.msk = MSK_CARRY;
            end
            default: ;
        endcase
        if (!op_valid) begin
            out_d.we  = 1'b0;
            out_d.msk = '0;
        end
    end

    assign result    = out_d.res;
    assign result_we = out_d.we;
    assign flag_next = out_d.fl;
    assign flag_mask = out_d.msk;

    acc_alu_flagreg #(.DATA_W(DATA_W), .FLAG_LSB(FLAG_LSB)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_mask(flag_mask),
        .upd_val (flag_next),
        .flags_q (flags_q)
    );

    a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_CMP) |-> (!result_we && flag_next[2] && flag_mask == MSK_ALL));

    a_r4_and_half_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_AND) |-> (flag_next[1] && !flag_next[0] && !flag_next[2]));

    a_r6_step_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_INC || op_sel == OP_DEC)) |-> !flag_mask[0]);

    a_r8_scf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_SCF) |-> (!result_we && flag_next[0] && !flag_mask[3]));

    a_r1_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (result_we && flag_mask[3]) |-> (flag_next[3] == (result == '0)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (flag_mask == '0 && !result_we));

endmodule

// File: tb/sim_acc_alu_core.sv
module sim_acc_alu_core;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       result_we;
    logic [3:0] flag_next;
    logic [3:0] flag_mask;
    logic [7:0] flags_q;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_flags = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu_core u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
        .result(result), .result_we(result_we), .flag_next(flag_next),
        .flag_mask(flag_mask), .flags_q(flags_q)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // model written from the requirements: flags packed Z,N,H,C in bits 3..0
    task automatic model(input int op, input int a, input int b, input int ci,
                         output int res, output int we, output int fl, output int msk);
        int z, n, h, c, t;
        res = 0; we = 0; fl = 0; msk = 0;
        z = 0; n = 0; h = 0; c = 0;
        case (op)
            0, 1: begin
                t = (op == 1) ? ci : 0;
                res = (a + b + t) % 256;
                h = ((a % 16) + (b % 16) + t) > 15;
                c = (a + b + t) > 255;
                we = 1; msk = 15;
            end
            2, 3, 4: begin
                t = (op == 3) ? ci : 0;
                res = (a - b - t + 512) % 256;
                n = 1;
                h = (a % 16) < ((b % 16) + t);
                c = a < (b + t);
                we = (op != 4); msk = 15;
            end
            5: begin res = a & b; h = 1; we = 1; msk = 15; end
            6: begin res = a | b; we = 1; msk = 15; end
            7: begin res = a ^ b; we = 1; msk = 15; end
            8: begin res = (b + 1) % 256; h = (b % 16) == 15; we = 1; msk = 14; end
            9: begin res = (b + 255) % 256; n = 1; h = (b % 16) == 0; we = 1; msk = 14; end
            10: begin res = 255 - a; n = 1; h = 1; we = 1; msk = 6; end
            11: begin c = 1; msk = 7; end
            12: begin c = (ci == 0); msk = 7; end
            default: ;
        endcase
        z = (res == 0);
        fl = z * 8 + n * 4 + h * 2 + c;
    endtask

    // drive one operation, check outputs, clock it, check the flag byte
    task automatic do_op(input string tag, input int op, input int a, input int b,
                         input int ci, input int valid);
        int res, we, fl, msk;
        model(op, a, b, ci, res, we, fl, msk);
        if (valid == 0) begin we = 0; msk = 0; end
        @(negedge clk);
        op_valid = valid[0]; op_sel = op[3:0];
        acc_in = a[7:0]; opnd_in = b[7:0]; carry_in = ci[0];
        #1;
        chk(tag, "result_we", int'(result_we), we);
        if (we != 0) chk(tag, "result", int'(result), res);
        chk(tag, "flag_mask", int'(flag_mask), msk);
        chk(tag, "flag_next(masked)", int'(flag_next) & msk, fl & msk);
        for (int i = 0; i < 4; i++)
            if (msk[i]) begin
                if (fl[i]) exp_flags = exp_flags | (1 << (4 + i));
                else       exp_flags = exp_flags & ~(1 << (4 + i));
            end
        @(posedge clk);
        #1;
        chk(tag, "flags_q", int'(flags_q), exp_flags);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9", "flags_q after reset", int'(flags_q), 0);
        chk("R10", "idle result_we", int'(result_we), 0);
    endtask

    task automatic t_add();
        do_op("R1", 0, 8'h0F, 8'h01, 0, 1);   // half carry only
        do_op("R1", 0, 8'hFF, 8'h01, 0, 1);   // zero, half and full carry
        do_op("R1", 1, 8'h0E, 8'h01, 1, 1);   // carry-in makes the half carry
        do_op("R1", 1, 8'hFE, 8'h01, 1, 1);   // carry-in makes the full carry
        do_op("R1", 0, 8'h80, 8'h80, 1, 1);   // carry-in ignored by plain add
    endtask

    task automatic t_sub();
        do_op("R2", 2, 8'h10, 8'h01, 0, 1);   // low nibble borrow
        do_op("R2", 2, 8'h42, 8'h42, 0, 1);   // zero
        do_op("R2", 3, 8'h00, 8'h00, 1, 1);   // borrow from carry-in only
        do_op("R2", 3, 8'h05, 8'h05, 1, 1);
        do_op("R2", 2, 8'h05, 8'h07, 0, 1);
    endtask

    task automatic t_cmp();
        do_op("R3", 4, 8'h05, 8'h07, 0, 1);
        do_op("R3", 4, 8'h33, 8'h33, 1, 1);
    endtask

    task automatic t_logic();
        do_op("R4", 5, 8'hF0, 8'h0F, 1, 1);   // zero result, H forced
        do_op("R4", 5, 8'hFF, 8'h81, 0, 1);
        do_op("R5", 6, 8'h00, 8'h00, 1, 1);
        do_op("R5", 6, 8'h50, 8'h0A, 0, 1);
        do_op("R5", 7, 8'hAA, 8'hAA, 0, 1);
        do_op("R5", 7, 8'hAA, 8'h55, 0, 1);
    endtask

    task automatic t_step();
        do_op("R1", 0, 8'hFF, 8'h01, 0, 1);   // set C first
        do_op("R6", 8, 8'h00, 8'h0F, 0, 1);   // carry out of bit 3, C kept
        do_op("R6", 8, 8'h00, 8'hFF, 0, 1);   // wraps to zero, C kept
        do_op("R6", 9, 8'h00, 8'h10, 0, 1);   // nibble borrow
        do_op("R6", 9, 8'h00, 8'h01, 0, 1);   // zero
        do_op("R6", 9, 8'h00, 8'h00, 0, 1);   // wraps to FF
    endtask

    task automatic t_cpl();
        do_op("R5", 7, 8'h01, 8'h00, 0, 1);   // Z=0, C=0 baseline
        do_op("R7", 10, 8'h5A, 8'h00, 0, 1);
        do_op("R7", 10, 8'hFF, 8'h00, 1, 1);  // zero result must not touch Z
    endtask

    task automatic t_carry_ops();
        do_op("R5", 6, 8'h00, 8'h00, 0, 1);   // Z=1 baseline
        do_op("R8", 11, 8'h12, 8'h34, 0, 1);
        do_op("R8", 12, 8'h12, 8'h34, 1, 1);
        do_op("R8", 12, 8'h12, 8'h34, 0, 1);
    endtask

    task automatic t_gating();
        do_op("R10", 0, 8'hFF, 8'h01, 0, 1);  // flags to Z,H,C
        do_op("R10", 2, 8'h01, 8'h01, 0, 0);  // not valid: nothing moves
        do_op("R10", 6, 8'h01, 8'h00, 0, 0);
        for (int code = 13; code < 16; code++)
            do_op("R11", code, 8'h00, 8'h00, 1, 1);
    endtask

    task automatic t_sweep();
        for (int op = 0; op < 13; op++)
            for (int a = 0; a < 256; a += 37)
                for (int b = 3; b < 256; b += 53)
                    for (int ci = 0; ci < 2; ci++)
                        do_op("R9", op, a, b, ci, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_step();
        t_cpl();
        t_carry_ops();
        t_gating();
        t_sweep();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule